// File: doc/BRIEF.md
# Register Rename Unit with Commit-Time Recycling

This block sits in the decode path of an out-of-order core. Each cycle it can take one decoded instruction, carrying two source register indices and an optional destination index. It translates each source into the physical register that currently holds its newest value. If no physical register holds that value, it reports that the source should be read from the architected file. When the instruction writes a register, the block takes a fresh physical register from a first-in, first-out free pool and records the new mapping in its alias table. Both translations come back together on a registered response one cycle after the request is accepted.

When an instruction retires, the commit port supplies its architected destination, its physical tag and its result value. The value is written into the architected register file, which can be read through a synchronous read port. The alias table entry for that register is reset to "read the architected file" only when it still names the committing physical register. A physical register goes back to the pool only after two things are true: it has committed, and every younger instruction that was renamed to read it has reported that read through the operand-read port.

When the pool is empty, the stall output is raised. Requests presented during a stall are dropped.

Top module: `rename_unit`

## Requirements
- R1: After reset, stall is low, rsp_valid is low, every source translates to the architected file, and the pool hands out tags 0, 1, 2, ... in ascending order.
- R2: A request is accepted in a cycle where ren_valid is high and stall is low. Exactly one cycle later rsp_valid is high for one cycle. rsp_dst_en copies the request's destination flag, and rsp_dst_tag is the tag taken from the pool head.
- R3: A source whose register has a live mapping reports rsp_src_*_arf = 0 and the tag of the newest writer renamed before it. The instruction's own destination never affects its own sources.
- R4: A source with no live mapping reports rsp_src_*_arf = 1.
- R5: Freed tags join the tail of the pool. They are handed out again only after every tag that was already waiting in the pool.
- R6: A commit writes cmt_data into architected slot cmt_arch. arf_rd_data shows the slot selected by arf_rd_idx one cycle after that index is presented.
- R7: A commit clears the alias entry of cmt_arch only if the entry still maps to cmt_tag. Otherwise the newer mapping stays in place.
- R8: A tag returns to the pool only once it has committed and every source that was translated to it has been reported on the operand-read port. One report removes one reader.
- R9: Stall is high exactly while the pool is empty. A request made while stalled produces no response and consumes no tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request present |
| ren_src_a | input | AIW | First source architected index |
| ren_src_b | input | AIW | Second source architected index |
| ren_dst | input | AIW | Destination architected index |
| ren_dst_en | input | 1 | Instruction writes a destination |
| stall | output | 1 | Free pool empty; requests are not taken |
| rsp_valid | output | 1 | Rename response present |
| rsp_src_a_arf | output | 1 | First source reads the architected file |
| rsp_src_a_tag | output | PTW | First source physical tag (0 when arf) |
| rsp_src_b_arf | output | 1 | Second source reads the architected file |
| rsp_src_b_tag | output | PTW | Second source physical tag (0 when arf) |
| rsp_dst_en | output | 1 | A destination tag was assigned |
| rsp_dst_tag | output | PTW | Assigned destination physical tag |
| rd_done_valid | input | 1 | One pending read of a physical register has happened |
| rd_done_tag | input | PTW | Physical tag that was read |
| cmt_valid | input | 1 | Commit present |
| cmt_arch | input | AIW | Architected destination of the committing instruction |
| cmt_tag | input | PTW | Physical tag of the committing instruction |
| cmt_data | input | DATA_W | Result value to make architectural |
| arf_rd_idx | input | AIW | Architected file read index |
| arf_rd_data | output | DATA_W | Architected file read data, one cycle later |

## Verification
The translation path is exercised with three patterns. A chain of writers to the same register shows that a source follows only the newest mapping. An instruction that reads and writes the same register shows that its source still sees the older mapping. Reads of never-written registers separate live mappings from architected-file reads. Two commit patterns check the conditional clear: one where a younger writer has remapped the register first, and one where the committing tag is still the newest mapping. Reader reports are given in an order different from the order of the commits, and the pool is then drained completely. The tags handed out in that drain reveal both the tail-append order and a tag that is held back by a reader still outstanding. A request made while the pool is empty must produce nothing and leave the next assigned tag unchanged.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;
  // index width for a table of n entries, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rn_free_fifo.sv
`timescale 1ns/1ps
module rn_free_fifo #(
  parameter int DEPTH = 16,
  parameter int TW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  output logic [TW-1:0] head_tag,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  output logic          empty,
  output logic [CW-1:0] level
);
  localparam logic [TW-1:0] LAST = TW'(DEPTH - 1);

  logic [TW-1:0] slot [DEPTH];
  logic [TW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] level_q;

  function automatic logic [TW-1:0] step(input logic [TW-1:0] p);
    return (p == LAST) ? '0 : p + TW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= TW'(i);
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      level_q <= CW'(DEPTH);
    end else begin
      if (pop) rd_ptr <= step(rd_ptr);
      if (push) begin
        slot[wr_ptr] <= push_tag;
        wr_ptr       <= step(wr_ptr);
      end
      level_q <= level_q + CW'(push) - CW'(pop);
    end
  end

  assign head_tag = slot[rd_ptr];
  assign empty    = (level_q == '0);
  assign level    = level_q;
endmodule

// File: rtl/rn_alias_table.sv
`timescale 1ns/1ps
module rn_alias_table #(
  parameter int ENTRIES = 6,
  parameter int IW      = 3,
  parameter int TW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] look_a_idx,
  output logic          look_a_live,
  output logic [TW-1:0] look_a_tag,
  input  logic [IW-1:0] look_b_idx,
  output logic          look_b_live,
  output logic [TW-1:0] look_b_tag,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic [TW-1:0] set_tag,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  input  logic [TW-1:0] clr_tag
);
  logic          live_q [ENTRIES];
  logic [TW-1:0] tag_q  [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        live_q[e] <= 1'b0;
        tag_q[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (set_en && set_idx == IW'(e)) begin
          // a new writer always wins over a commit in the same cycle
          live_q[e] <= 1'b1;
          tag_q[e]  <= set_tag;
        end else if (clr_en && clr_idx == IW'(e) && live_q[e] && tag_q[e] == clr_tag) begin
          live_q[e] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    look_a_live = 1'b0;
    look_a_tag  = '0;
    look_b_live = 1'b0;
    look_b_tag  = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (look_a_idx == IW'(e)) begin
        look_a_live = live_q[e];
        look_a_tag  = tag_q[e];
      end
      if (look_b_idx == IW'(e)) begin
        look_b_live = live_q[e];
        look_b_tag  = tag_q[e];
      end
    end
  end
endmodule

// File: rtl/rn_reader_track.sv
`timescale 1ns/1ps
module rn_reader_track #(
  parameter int ENTRIES = 16,
  parameter int TW      = 4,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_a_en,
  input  logic [TW-1:0] inc_a_tag,
  input  logic          inc_b_en,
  input  logic [TW-1:0] inc_b_tag,
  input  logic          dec_en,
  input  logic [TW-1:0] dec_tag,
  input  logic          done_en,
  input  logic [TW-1:0] done_tag,
  output logic          rel_valid,
  output logic [TW-1:0] rel_tag
);
  logic [CW-1:0]      cnt_q [ENTRIES];
  logic [ENTRIES-1:0] done_q;

  // lowest-numbered register that is committed and unread is freed first
  always_comb begin
    rel_valid = 1'b0;
    rel_tag   = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!rel_valid && done_q[e] && cnt_q[e] == '0) begin
        rel_valid = 1'b1;
        rel_tag   = TW'(e);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) cnt_q[e] <= '0;
      done_q <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        cnt_q[e] <= cnt_q[e]
                    + CW'(inc_a_en && inc_a_tag == TW'(e))
                    + CW'(inc_b_en && inc_b_tag == TW'(e))
                    - CW'(dec_en && dec_tag == TW'(e));
        if (done_en && done_tag == TW'(e))
          done_q[e] <= 1'b1;
        else if (rel_valid && rel_tag == TW'(e))
          done_q[e] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rn_arch_file.sv
`timescale 1ns/1ps
module rn_arch_file #(
  parameter int IW = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  localparam int SLOTS = 1 << IW;

  logic [DW-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/rename_unit.sv
`timescale 1ns/1ps
module rename_unit #(
  parameter int ARCH_REGS = 6,
  parameter int PHYS_REGS = 16,
  parameter int DATA_W    = 16,
  parameter int RDR_CNT_W = 4,
  localparam int AIW = rn_pkg::idx_w(ARCH_REGS),
  localparam int PTW = rn_pkg::idx_w(PHYS_REGS),
  localparam int FCW = $clog2(PHYS_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ren_valid,
  input  logic [AIW-1:0]    ren_src_a,
  input  logic [AIW-1:0]    ren_src_b,
  input  logic [AIW-1:0]    ren_dst,
  input  logic              ren_dst_en,
  output logic              stall,
  output logic              rsp_valid,
  output logic              rsp_src_a_arf,
  output logic [PTW-1:0]    rsp_src_a_tag,
  output logic              rsp_src_b_arf,
  output logic [PTW-1:0]    rsp_src_b_tag,
  output logic              rsp_dst_en,
  output logic [PTW-1:0]    rsp_dst_tag,
  input  logic              rd_done_valid,
  input  logic [PTW-1:0]    rd_done_tag,
  input  logic              cmt_valid,
  input  logic [AIW-1:0]    cmt_arch,
  input  logic [PTW-1:0]    cmt_tag,
  input  logic [DATA_W-1:0] cmt_data,
  input  logic [AIW-1:0]    arf_rd_idx,
  output logic [DATA_W-1:0] arf_rd_data
);
  logic           pool_empty;
  logic [PTW-1:0] pool_head;
  logic [FCW-1:0] free_level;
  logic           accept, alloc;
  logic           a_live, b_live;
  logic [PTW-1:0] a_tag, b_tag;
  logic           rel_valid;
  logic [PTW-1:0] rel_tag;

  assign stall  = pool_empty;
  assign accept = ren_valid && !pool_empty;
  assign alloc  = accept && ren_dst_en;

  rn_free_fifo #(.DEPTH(PHYS_REGS), .TW(PTW), .CW(FCW)) u_pool (
    .clk(clk), .rst(rst),
    .pop(alloc), .head_tag(pool_head),
    .push(rel_valid), .push_tag(rel_tag),
    .empty(pool_empty), .level(free_level)
  );

  rn_alias_table #(.ENTRIES(ARCH_REGS), .IW(AIW), .TW(PTW)) u_map (
    .clk(clk), .rst(rst),
    .look_a_idx(ren_src_a), .look_a_live(a_live), .look_a_tag(a_tag),
    .look_b_idx(ren_src_b), .look_b_live(b_live), .look_b_tag(b_tag),
    .set_en(alloc), .set_idx(ren_dst), .set_tag(pool_head),
    .clr_en(cmt_valid), .clr_idx(cmt_arch), .clr_tag(cmt_tag)
  );

  rn_reader_track #(.ENTRIES(PHYS_REGS), .TW(PTW), .CW(RDR_CNT_W)) u_readers (
    .clk(clk), .rst(rst),
    .inc_a_en(accept && a_live), .inc_a_tag(a_tag),
    .inc_b_en(accept && b_live), .inc_b_tag(b_tag),
    .dec_en(rd_done_valid), .dec_tag(rd_done_tag),
    .done_en(cmt_valid), .done_tag(cmt_tag),
    .rel_valid(rel_valid), .rel_tag(rel_tag)
  );

  rn_arch_file #(.IW(AIW), .DW(DATA_W)) u_arf (
    .clk(clk),
    .wr_en(cmt_valid), .wr_idx(cmt_arch), .wr_data(cmt_data),
    .rd_idx(arf_rd_idx), .rd_data(arf_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_src_a_arf <= 1'b1;
      rsp_src_a_tag <= '0;
      rsp_src_b_arf <= 1'b1;
      rsp_src_b_tag <= '0;
      rsp_dst_en    <= 1'b0;
      rsp_dst_tag   <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_src_a_arf <= !a_live;
        rsp_src_a_tag <= a_live ? a_tag : '0;
        rsp_src_b_arf <= !b_live;
        rsp_src_b_tag <= b_live ? b_tag : '0;
        rsp_dst_en    <= ren_dst_en;
        rsp_dst_tag   <= ren_dst_en ? pool_head : '0;
      end
    end
  end
endmodule

// File: rtl/rename_unit_chk.sv
`timescale 1ns/1ps
module rename_unit_chk #(
  parameter int PHYS_REGS = 16,
  parameter int PTW       = 4,
  parameter int FCW       = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           ren_valid,
  input logic           stall,
  input logic           rsp_valid,
  input logic           rsp_dst_en,
  input logic           rsp_src_a_arf,
  input logic [PTW-1:0] rsp_src_a_tag,
  input logic           rsp_src_b_arf,
  input logic [PTW-1:0] rsp_src_b_tag,
  input logic [PTW-1:0] rsp_dst_tag,
  input logic [FCW-1:0] free_level
);
  // R1
  reset_all_free_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!stall && int'(free_level) == PHYS_REGS));

  // R2
  rsp_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(ren_valid && !stall));

  // R9
  stalled_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !rsp_valid);

  // R3
  fresh_dst_a_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_dst_en && !rsp_src_a_arf) |-> rsp_dst_tag != rsp_src_a_tag);

  // R3
  fresh_dst_b_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_dst_en && !rsp_src_b_arf) |-> rsp_dst_tag != rsp_src_b_tag);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(free_level) <= PHYS_REGS);

  // R8
  one_return_per_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> int'(free_level) <= int'($past(free_level)) + 1);
endmodule

bind rename_unit rename_unit_chk #(.PHYS_REGS(PHYS_REGS), .PTW(PTW), .FCW(FCW)) i_chk (
  .clk(clk), .rst(rst), .ren_valid(ren_valid), .stall(stall),
  .rsp_valid(rsp_valid), .rsp_dst_en(rsp_dst_en),
  .rsp_src_a_arf(rsp_src_a_arf), .rsp_src_a_tag(rsp_src_a_tag),
  .rsp_src_b_arf(rsp_src_b_arf), .rsp_src_b_tag(rsp_src_b_tag),
  .rsp_dst_tag(rsp_dst_tag), .free_level(free_level)
);

// File: tb/test_rename_unit.sv
`timescale 1ns/1ps
module test_rename_unit;
  localparam int AIW = 3;
  localparam int PTW = 4;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic           ren_valid = 0, ren_dst_en = 0;
  logic [AIW-1:0] ren_src_a = 0, ren_src_b = 0, ren_dst = 0;
  logic           stall, rsp_valid, rsp_src_a_arf, rsp_src_b_arf, rsp_dst_en;
  logic [PTW-1:0] rsp_src_a_tag, rsp_src_b_tag, rsp_dst_tag;
  logic           rd_done_valid = 0;
  logic [PTW-1:0] rd_done_tag = 0;
  logic           cmt_valid = 0;
  logic [AIW-1:0] cmt_arch = 0;
  logic [PTW-1:0] cmt_tag = 0;
  logic [DW-1:0]  cmt_data = 0;
  logic [AIW-1:0] arf_rd_idx = 0;
  logic [DW-1:0]  arf_rd_data;

  rename_unit i_rename_unit (
    .clk(clk), .rst(rst),
    .ren_valid(ren_valid), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
    .ren_dst(ren_dst), .ren_dst_en(ren_dst_en), .stall(stall),
    .rsp_valid(rsp_valid), .rsp_src_a_arf(rsp_src_a_arf), .rsp_src_a_tag(rsp_src_a_tag),
    .rsp_src_b_arf(rsp_src_b_arf), .rsp_src_b_tag(rsp_src_b_tag),
    .rsp_dst_en(rsp_dst_en), .rsp_dst_tag(rsp_dst_tag),
    .rd_done_valid(rd_done_valid), .rd_done_tag(rd_done_tag),
    .cmt_valid(cmt_valid), .cmt_arch(cmt_arch), .cmt_tag(cmt_tag), .cmt_data(cmt_data),
    .arf_rd_idx(arf_rd_idx), .arf_rd_data(arf_rd_data)
  );

  typedef struct {
    string req;
    bit    a_arf;
    int    a_tag;
    bit    b_arf;
    int    b_tag;
    bit    d_en;
    int    d_tag;
  } exp_t;

  exp_t expq[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 0;

  task automatic check(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: compare each response against the oldest expectation
  exp_t got;
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (expq.size() == 0) begin
        n_vec++;
        n_bad++;
        $display("FAIL R9 unexpected response: actual 1 expected 0");
      end else begin
        got = expq.pop_front();
        check(got.req, "src_a arf", int'(rsp_src_a_arf), int'(got.a_arf));
        if (!got.a_arf) check(got.req, "src_a tag", int'(rsp_src_a_tag), got.a_tag);
        check(got.req, "src_b arf", int'(rsp_src_b_arf), int'(got.b_arf));
        if (!got.b_arf) check(got.req, "src_b tag", int'(rsp_src_b_tag), got.b_tag);
        check(got.req, "dst en", int'(rsp_dst_en), int'(got.d_en));
        if (got.d_en) check(got.req, "dst tag", int'(rsp_dst_tag), got.d_tag);
      end
    end
  end

  task automatic rename(string req, int a, int b, int d, bit den,
                        bit ea_arf, int ea_tag, bit eb_arf, int eb_tag, int ed_tag);
    exp_t e;
    e.req = req; e.a_arf = ea_arf; e.a_tag = ea_tag;
    e.b_arf = eb_arf; e.b_tag = eb_tag; e.d_en = den; e.d_tag = ed_tag;
    expq.push_back(e);
    ren_valid  = 1'b1;
    ren_src_a  = AIW'(a);
    ren_src_b  = AIW'(b);
    ren_dst    = AIW'(d);
    ren_dst_en = den;
    @(negedge clk);
    ren_valid  = 1'b0;
    ren_dst_en = 1'b0;
  endtask

  task automatic commit(int arch, int tag, int data);
    cmt_valid = 1'b1;
    cmt_arch  = AIW'(arch);
    cmt_tag   = PTW'(tag);
    cmt_data  = DW'(data);
    @(negedge clk);
    cmt_valid = 1'b0;
  endtask

  task automatic read_done(int tag);
    rd_done_valid = 1'b1;
    rd_done_tag   = PTW'(tag);
    @(negedge clk);
    rd_done_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arf_check(string req, int idx, int exp);
    arf_rd_idx = AIW'(idx);
    @(negedge clk);
    check(req, "arf read", int'(arf_rd_data), exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check("R1", "stall", int'(stall), 0);
    check("R1", "rsp_valid", int'(rsp_valid), 0);

    // R1 R4: nothing mapped, first tag is 0
    rename("R1", 1, 2, 1, 1, 1, 0, 1, 0, 0);
    // R3: r1 -> tag0
    rename("R3", 1, 3, 2, 1, 0, 0, 1, 0, 1);
    // R3: own destination does not affect own source
    rename("R3", 2, 1, 1, 1, 0, 1, 0, 0, 2);
    // R7: r1 now maps to tag2, commit of tag0 must leave it
    commit(1, 0, 16'hAAAA);
    rename("R7", 1, 4, 0, 0, 0, 2, 1, 0, 0);
    arf_check("R6", 1, 16'hAAAA);
    // R7: r2 still maps tag1, commit clears it
    commit(2, 1, 16'h1234);
    rename("R7", 2, 2, 0, 0, 1, 0, 1, 0, 0);
    arf_check("R6", 2, 16'h1234);
    commit(1, 2, 16'h5555);
    rename("R4", 1, 0, 0, 0, 1, 0, 1, 0, 0);
    arf_check("R6", 1, 16'h5555);

    // R8: tag1 freed first, then tag0; tag2 keeps one reader
    read_done(1);
    read_done(0);
    read_done(0);
    idle(3);

    // R5: drain the pool, order 3..15 then 1, 0
    for (int k = 0; k < 15; k++)
      rename("R5", 0, 0, 5, 1, 1, 0, 1, 0, (k < 13) ? k + 3 : ((k == 13) ? 1 : 0));
    check("R9", "stall when empty", int'(stall), 1);

    // R9: request while stalled is dropped
    ren_valid = 1'b1; ren_src_a = 3'd1; ren_src_b = 3'd1; ren_dst = 3'd3; ren_dst_en = 1'b1;
    @(negedge clk);
    ren_valid = 1'b0; ren_dst_en = 1'b0;
    idle(2);
    check("R9", "stall held", int'(stall), 1);

    // R8: committed tag0 with no readers returns; r5 mapping cleared (R7)
    commit(5, 0, 16'h0F0F);
    idle(3);
    check("R8", "stall after release", int'(stall), 0);
    arf_check("R6", 5, 16'h0F0F);
    rename("R9", 5, 0, 3, 1, 1, 0, 1, 0, 0);
    check("R8", "tag2 held by reader", int'(stall), 1);

    // R8: last reader of tag2 reported
    read_done(2);
    idle(3);
    check("R8", "stall after last read", int'(stall), 0);
    rename("R8", 0, 0, 4, 1, 1, 0, 1, 0, 2);
    idle(2);
    check("R2", "pending responses", expq.size(), 0);
    finish_run();
  end
endmodule